// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Write Controller

This block sits behind a serial memory front end and handles the data phase of a memory write instruction. The front end gives it the start address of the write, a strobe for each complete data byte, a pulse when chip select is released, and a flag that says whether the serial sequence ended on a byte boundary. A protection unit gives it a permit bit with every byte. Bytes go into a page buffer that holds one page. Each entry has its own loaded flag.

When chip select rises after a valid sequence with at least one byte, the block starts a self-timed programming cycle. It reports busy for a fixed number of system clocks. In the first clocks of that cycle it sends every loaded entry to the array write port, one entry per clock, in ascending offset order. When the cycle ends it gives a one-clock pulse that clears the write enable latch. For a set number of clocks after reset, write starts are refused, which models the power-up delay.

Top module: `page_prog`

## Requirements
- R1: A write begins at the offset given by the low log2(PAGE_BYTES) bits of the start address. The upper address bits form the page, and they are the upper bits of every array address written by that cycle. Each accepted byte goes to the current offset, and the offset then advances by one.
- R2: An offset that passes PAGE_BYTES-1 wraps to 0 in the same page. A later byte for an offset that already holds one replaces the earlier byte.
- R3: A programming cycle starts only when a chip-select-rise pulse arrives while loading, with the sequence-valid flag at 1 and at least one byte received. Any other chip-select rise ends the load and discards the buffer without starting a cycle.
- R4: busy_o goes to 1 on the clock after the starting chip-select rise and stays at 1 for exactly WR_CYCLES clocks.
- R5: wel_clr_o pulses for exactly one clock, in the first clock in which busy_o is 0 again after a cycle, and at no other time.
- R6: During the first PAGE_BYTES clocks of busy, the clock with busy index k (0 for the first busy clock) writes offset k of the page if that entry was loaded with its permit bit at 1. Entries that are not loaded, or whose last byte had permit 0, are not written. No array write happens at any other time.
- R7: While busy_o is 1, start, byte and chip-select-rise inputs are ignored.
- R8: A start that arrives before PWRUP_CYCLES clocks have passed since reset is ignored, and so are the bytes that follow it.
- R9: In reset, busy_o, arr_we_o and wel_clr_o are 0.
- R10: A new start while loading discards all bytes loaded so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Write data phase begins; addr_i is valid |
| addr_i | input | ADDR_W | Start address of the write |
| byte_vld_i | input | 1 | A complete data byte is on byte_i |
| byte_i | input | 8 | Data byte |
| permit_i | input | 1 | Protection permits the byte on byte_i |
| cs_rise_i | input | 1 | Chip select went high |
| seq_ok_i | input | 1 | Sequence ended on a byte boundary; valid with cs_rise_i |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | Clear write enable latch, one-clock pulse |

## Verification
The bench runs the following writes: a short write starting mid-page, which checks that the page bits and offset split correctly; a write of more bytes than a page holds, starting near the end of the page, which checks wrap and overwrite; and a write with mixed permit bits, which checks the per-entry loaded flags. Sequences that end off a byte boundary or with no data separate a valid chip-select rise from an invalid one. A restart in mid-load shows whether stale entries survive. Traffic sent during busy and before the power-up delay ends shows whether the block's gating holds. A reference model with a behavioural buffer is compared against the write port, busy and latch-clear outputs on every clock.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pp_state_e;
endpackage

// File: rtl/pp_pwrup.sv
module pp_pwrup #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == LIM);
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int unsigned PAGE_BYTES = 32,
  localparam int unsigned OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             wr_i,
  input  logic [7:0]       data_i,
  input  logic             permit_i,
  input  logic [OFS_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [7:0]       rd_data_o,
  output logic             got_o
);
  logic [OFS_W-1:0]            ptr_q;
  logic                        got_q;
  logic [PAGE_BYTES-1:0]       vld_q;
  logic [PAGE_BYTES-1:0]       hit;
  logic [PAGE_BYTES-1:0][7:0]  mem_q;

  // one-hot entry select; pointer wraps by width (power-of-two page)
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_hit
    assign hit[i] = wr_i && (ptr_q == OFS_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      got_q <= 1'b0;
      vld_q <= '0;
    end else if (clr_i) begin
      ptr_q <= ofs_i;
      got_q <= 1'b0;
      vld_q <= '0;
    end else if (wr_i) begin
      ptr_q <= ptr_q + 1'b1;
      got_q <= 1'b1;
      for (int i = 0; i < PAGE_BYTES; i++)
        if (hit[i]) vld_q[i] <= permit_i;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PAGE_BYTES; i++)
      if (hit[i]) mem_q[i] <= data_i;
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_data_o = mem_q[rd_idx_i];
  assign got_o     = got_q;
endmodule

// File: rtl/pp_wr_timer.sv
module pp_wr_timer #(
  parameter int unsigned CYC = 64,
  localparam int unsigned CW = $clog2(CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          run_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] END_V = CW'(CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go_i && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == END_V) run_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign last_o = run_q && (cnt_q == END_V);
endmodule

// File: rtl/page_prog.sv
module page_prog
  import page_prog_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned WR_CYCLES    = 625000,
  parameter int unsigned PWRUP_CYCLES = 125000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              permit_i,
  input  logic              cs_rise_i,
  input  logic              seq_ok_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned TMR_W  = $clog2(WR_CYCLES);
  localparam logic [TMR_W-1:0] SCAN_END = TMR_W'(PAGE_BYTES);

  pp_state_e         st_q, st_d;
  logic [PAGE_W-1:0] page_q;
  logic              wclr_q;
  logic              pwr_ok;
  logic              take_start, take_byte, go;
  logic              got, rd_vld;
  logic [7:0]        rd_data;
  logic              tmr_run, tmr_last;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              scan_act;

  pp_pwrup #(.CYC(PWRUP_CYCLES)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ok_o   (pwr_ok)
  );

  // chip-select rise wins over start, start over byte
  assign take_start = start_i && pwr_ok && !cs_rise_i && (st_q != ST_PROG);
  assign take_byte  = byte_vld_i && (st_q == ST_LOAD) && !cs_rise_i && !take_start;
  assign go         = (st_q == ST_LOAD) && cs_rise_i && seq_ok_i && got;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (take_start) st_d = ST_LOAD;
      ST_LOAD: if (cs_rise_i)  st_d = go ? ST_PROG : ST_IDLE;
      ST_PROG: if (tmr_last)   st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      wclr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wclr_q <= tmr_last;
      if (take_start) page_q <= addr_i[ADDR_W-1:OFS_W];
    end
  end

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (take_start),
    .ofs_i     (addr_i[OFS_W-1:0]),
    .wr_i      (take_byte),
    .data_i    (byte_i),
    .permit_i  (permit_i),
    .rd_idx_i  (tmr_cnt[OFS_W-1:0]),
    .rd_vld_o  (rd_vld),
    .rd_data_o (rd_data),
    .got_o     (got)
  );

  pp_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .run_o  (tmr_run),
    .cnt_o  (tmr_cnt),
    .last_o (tmr_last)
  );

  assign scan_act   = tmr_run && (tmr_cnt < SCAN_END);
  assign arr_we_o   = scan_act && rd_vld;
  assign arr_addr_o = {page_q, tmr_cnt[OFS_W-1:0]};
  assign arr_data_o = rd_data;
  assign busy_o     = (st_q == ST_PROG);
  assign wel_clr_o  = wclr_q;
endmodule

// File: rtl/page_prog_chk.sv
module page_prog_chk #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WR_CYCLES  = 625000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cs_rise_i,
  input logic              seq_ok_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o,
  input logic              wel_clr_o
);
  localparam int unsigned OFS_W = $clog2(PAGE_BYTES);
  localparam int unsigned BW    = $clog2(WR_CYCLES + 1);

  logic [BW-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  assert_start_on_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i) && $past(seq_ok_i));

  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len <= BW'(WR_CYCLES));

  assert_busy_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == BW'(WR_CYCLES));

  assert_wclr_on_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> $fell(busy_o));

  assert_end_gives_wclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> wel_clr_o);

  assert_we_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  assert_page_const_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> $stable(arr_addr_o[ADDR_W-1:OFS_W]));

  assert_ascend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[OFS_W-1:0] > $past(arr_addr_o[OFS_W-1:0]));

  always_comb if (!rst_ni) assert_reset_quiet_R9: assert (!arr_we_o && !wel_clr_o);
endmodule

bind page_prog page_prog_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cs_rise_i  (cs_rise_i),
  .seq_ok_i   (seq_ok_i),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o),
  .busy_o     (busy_o),
  .wel_clr_o  (wel_clr_o)
);

// File: tb/page_prog_test.sv
module page_prog_test;
  localparam int AW = 11;
  localparam int PB = 32;
  localparam int WR = 40;
  localparam int PU = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_vld = 1'b0, permit = 1'b0, cs_rise = 1'b0, seq_ok = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] bdat = '0;
  logic we, busy, wclr;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R9";

  page_prog #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WR), .PWRUP_CYCLES(PU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .byte_vld_i(byte_vld), .byte_i(bdat), .permit_i(permit),
    .cs_rise_i(cs_rise), .seq_ok_i(seq_ok),
    .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata),
    .busy_o(busy), .wel_clr_o(wclr)
  );

  always #4 clk = ~clk;

  // reference model
  int  m_pwr = 0, m_t = 0, m_page = 0, m_ofs = 0, m_cnt = 0;
  bit  m_busy = 0, m_load = 0, m_wclr = 0;
  int  m_buf[PB];
  bit  m_vld[PB];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 0; m_busy = 0; m_load = 0; m_wclr = 0; m_t = 0; m_cnt = 0;
      foreach (m_vld[i]) m_vld[i] = 0;
    end else begin
      bit ok_pwr;
      ok_pwr = (m_pwr >= PU);
      if (m_pwr < PU) m_pwr++;
      m_wclr = 0;
      if (m_busy) begin
        if (m_t == WR-1) begin m_busy = 0; m_wclr = 1; end
        else m_t++;
      end else if (cs_rise) begin
        if (m_load && seq_ok && m_cnt > 0) begin m_busy = 1; m_t = 0; end
        m_load = 0;
      end else if (start && ok_pwr) begin
        m_load = 1; m_page = int'(addr) / PB; m_ofs = int'(addr) % PB; m_cnt = 0;
        foreach (m_vld[i]) m_vld[i] = 0;
      end else if (byte_vld && m_load) begin
        m_buf[m_ofs] = bdat; m_vld[m_ofs] = permit;
        m_ofs = (m_ofs + 1) % PB; m_cnt++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s/%s t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      bit e_we;
      e_we = m_busy && m_t < PB && m_vld[m_t % PB];
      chk("R4 busy", int'(busy), int'(m_busy));
      chk("R5 wel_clr", int'(wclr), int'(m_wclr));
      chk("R6 we", int'(we), int'(e_we));
      if (e_we) begin
        chk("R1 addr", int'(waddr), m_page * PB + m_t);
        chk("R2 data", int'(wdata), m_buf[m_t]);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic begin_wr(input int a);
    @(negedge clk); start = 1'b1; addr = AW'(a);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input int b, input bit p);
    @(negedge clk); byte_vld = 1'b1; bdat = 8'(b); permit = p;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic end_wr(input bit ok);
    @(negedge clk); cs_rise = 1'b1; seq_ok = ok;
    @(negedge clk); cs_rise = 1'b0; seq_ok = 1'b0;
  endtask

  initial begin
    tick(3);
    phase = "R9";
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 we in reset", int'(we), 0);
    chk("R9 wel_clr in reset", int'(wclr), 0);
    rst_n = 1'b1;

    phase = "R8";
    begin_wr(12'h100); send(8'h11, 1); send(8'h22, 1); end_wr(1);
    tick(12);
    chk("R8 no cycle before power-up", int'(busy), 0);

    phase = "R1";
    begin_wr(12'h123); send(8'hA1, 1); send(8'hA2, 1); send(8'hA3, 1); send(8'hA4, 1);
    end_wr(1); tick(WR + 4);

    phase = "R2";
    begin_wr(12'h25E);
    for (int i = 0; i < 36; i++) send(8'h40 + i, 1);
    end_wr(1); tick(WR + 4);

    phase = "R3";
    begin_wr(12'h300); send(8'h55, 1); send(8'h66, 1); end_wr(0); tick(4);
    chk("R3 invalid seq no busy", int'(busy), 0);
    begin_wr(12'h300); end_wr(1); tick(4);
    chk("R3 no bytes no busy", int'(busy), 0);
    end_wr(1); tick(4);
    chk("R3 stray cs rise", int'(busy), 0);

    phase = "R6";
    begin_wr(12'h080);
    for (int i = 0; i < 8; i++) send(8'h70 + i, i % 3 != 0);
    end_wr(1); tick(WR + 4);

    phase = "R7";
    begin_wr(12'h1C4); send(8'hC1, 1); end_wr(1);
    tick(2);
    begin_wr(12'h3E0); send(8'hEE, 1); send(8'hEF, 1); end_wr(1);
    tick(WR + 4);
    chk("R7 no second cycle", int'(busy), 0);

    phase = "R10";
    begin_wr(12'h040); send(8'h91, 1); send(8'h92, 1); send(8'h93, 1);
    begin_wr(12'h05A); send(8'h9F, 1); end_wr(1); tick(WR + 4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule